// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, for each received frame, whether its destination MAC address should be kept. It receives the 48-bit destination address with a one-cycle strobe. Configuration comes in as register-style inputs: four station-address slots, a four-bit recognition-control word and a 64-bit multicast hash table. Two cycles after the strobe it reports whether the frame is accepted, and whether the address is a multicast (group, non-broadcast) address.

Individual (unicast) addresses are compared against all four slots in parallel. The all-ones broadcast address has its own enable. Group addresses can be accepted all at once, or through a 64-bin hash. The bin index is the upper six bits of a bit-reflected Ethernet CRC-32 over the six address bytes, and the bits inside each 16-bit hash word are in reversed order. Promiscuous mode accepts every address. The filter keeps one lookup in flight: while the hash is being evaluated, it reports busy and ignores a further strobe.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, and after a reset that lands while a lookup is in flight, `res_valid`, `res_accept`, `res_mcast` and `busy` are all 0, and no result is produced for the interrupted lookup.
- R2: The first address byte arrives on `dst_addr[47:40]` and the sixth on `dst_addr[7:0]`. Slot k keeps its first two bytes in `sta_hi[16k+15:16k]`, with the first byte in the upper half. It keeps bytes three to six in `sta_lo[32k+31:32k]`, with byte three in bits [31:24].
- R3: An address whose group bit is 0 is accepted when it equals any one of the four slots, and is rejected otherwise, unless promiscuous mode is on. The hash and all-multicast enables have no effect on it.
- R4: The group bit is `dst_addr[40]`, which is bit 0 of the first byte. `res_mcast` is 1 exactly for addresses with that bit set that are not all ones.
- R5: The all-ones address is accepted only when `rcv_ctl[0]` (broadcast enable) or `rcv_ctl[1]` (promiscuous) is set. The all-multicast and hash enables do not accept it.
- R6: With `rcv_ctl[1]` set, every address is accepted.
- R7: With `rcv_ctl[2]` set, every multicast address is accepted.
- R8: With `rcv_ctl[3]` set, a multicast address is accepted when its hash bin is set. The CRC is bit-reflected, with polynomial 0xEDB88320 and initial value all ones, and no final inversion. It runs over the bytes first to last, each byte least significant bit first. The bin index i is CRC bits [31:26]. i[5:4] picks hash word w and i[3:0] = n picks bit 15-n of that word. Words 0 and 1 are the low and high halves of `hash_lo`; words 2 and 3 are the low and high halves of `hash_hi`.
- R9: For an accepted strobe in cycle c, `res_valid` is high for exactly one cycle, c+2, and carries the decision. `res_accept` and `res_mcast` are 0 whenever `res_valid` is 0.
- R10: In the cycle after an accepted strobe, `busy` is 1, and a strobe given in that cycle is ignored and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dst_valid | input | 1 | Address strobe |
| dst_addr | input | 48 | Destination address, first byte in [47:40] |
| sta_hi | input | 64 | Station slots, upper two bytes each |
| sta_lo | input | 128 | Station slots, lower four bytes each |
| rcv_ctl | input | 4 | [0] broadcast, [1] promiscuous, [2] all multicast, [3] hash multicast |
| hash_lo | input | 32 | Hash words 1 (upper half) and 0 (lower half) |
| hash_hi | input | 32 | Hash words 3 (upper half) and 2 (lower half) |
| busy | output | 1 | Lookup in flight; strobe ignored |
| res_valid | output | 1 | Result pulse |
| res_accept | output | 1 | Address accepted |
| res_mcast | output | 1 | Address is multicast, not broadcast |

## Verification
Every cycle, the assertions check the result timing and spacing, the quiet outputs between results, and the rule that the multicast flag appears only for group addresses. They also check that promiscuous mode and a slot hit force acceptance, and that broadcast is refused when its enables are off. The hash bin mapping can only be shown by the bench scenarios. The bench computes the CRC its own way and sets either the single correct bin or every other bin. The same holds for the exact slot field packing and the dropping of a strobe given while busy.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;
  localparam int MAC_W    = 48;
  localparam int MAC_BYTES = MAC_W / 8;
  localparam int HASH_W   = 64;
  localparam int HIDX_W   = $clog2(HASH_W);
  localparam int CTL_W    = 4;
  localparam int CTL_BCAST = 0;
  localparam int CTL_PROMISC = 1;
  localparam int CTL_ALLMC = 2;
  localparam int CTL_HASHMC = 3;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // Bit-serial reflected CRC-32, bytes first to last, LSB of each byte first.
  function automatic logic [31:0] crc32_refl(input logic [MAC_W-1:0] a);
    logic [31:0] c;
    logic fb;
    c = '1;
    for (int b = 0; b < MAC_BYTES; b++) begin
      for (int i = 0; i < 8; i++) begin
        fb = c[0] ^ a[MAC_W-1-8*b-7+i];
        c  = c >> 1;
        if (fb) c = c ^ CRC_POLY_REFL;
      end
    end
    return c;
  endfunction

  function automatic logic [HIDX_W-1:0] hash_index(input logic [MAC_W-1:0] a);
    logic [31:0] c;
    c = crc32_refl(a);
    return c[31:32-HIDX_W];
  endfunction

  // Word from upper index bits, reversed bit inside the 16-bit word.
  function automatic logic [HIDX_W-1:0] hash_bin_pos(input logic [HIDX_W-1:0] idx);
    return {idx[HIDX_W-1:4], ~idx[3:0]};
  endfunction
endpackage

// File: rtl/rx_addr_station_match.sv
module rx_addr_station_match
  import rx_addr_filter_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic [MAC_W-1:0]        addr,
  input  logic [NUM_SLOTS*16-1:0] slot_hi,
  input  logic [NUM_SLOTS*32-1:0] slot_lo,
  output logic [NUM_SLOTS-1:0]    slot_hit,
  output logic                    any_hit
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slot_hit[g] = ({slot_hi[g*16 +: 16], slot_lo[g*32 +: 32]} == addr);
  end
  assign any_hit = |slot_hit;
endmodule

// File: rtl/rx_addr_hash_lookup.sv
module rx_addr_hash_lookup
  import rx_addr_filter_pkg::*;
(
  input  logic [MAC_W-1:0]  addr,
  input  logic [HASH_W-1:0] table_bits,
  output logic [HIDX_W-1:0] bin_idx,
  output logic              bin_hit
);
  logic [HIDX_W-1:0] bin_pos;
  assign bin_idx = hash_index(addr);
  assign bin_pos = hash_bin_pos(bin_idx);
  assign bin_hit = table_bits[bin_pos];
endmodule

// File: rtl/rx_addr_decide.sv
module rx_addr_decide
  import rx_addr_filter_pkg::*;
(
  input  logic [MAC_W-1:0] addr,
  input  logic [CTL_W-1:0] ctl,
  input  logic             station_hit,
  input  logic             hash_hit,
  output logic             is_bcast,
  output logic             is_mcast,
  output logic             accept
);
  logic is_group;
  assign is_group = addr[MAC_W-8];
  assign is_bcast = &addr;
  assign is_mcast = is_group & ~is_bcast;
  always_comb begin
    accept = ctl[CTL_PROMISC];
    if (is_bcast && ctl[CTL_BCAST]) accept = 1'b1;
    if (!is_group && station_hit) accept = 1'b1;
    if (is_mcast && (ctl[CTL_ALLMC] || (ctl[CTL_HASHMC] && hash_hit))) accept = 1'b1;
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_addr_filter_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dst_valid,
  input  logic [MAC_W-1:0]        dst_addr,
  input  logic [NUM_SLOTS*16-1:0] sta_hi,
  input  logic [NUM_SLOTS*32-1:0] sta_lo,
  input  logic [CTL_W-1:0]        rcv_ctl,
  input  logic [HASH_W/2-1:0]     hash_lo,
  input  logic [HASH_W/2-1:0]     hash_hi,
  output logic                    busy,
  output logic                    res_valid,
  output logic                    res_accept,
  output logic                    res_mcast
);
  logic             s1_vld;
  logic [MAC_W-1:0] addr_q;
  logic             take;
  logic [NUM_SLOTS-1:0] slot_hit;
  logic             station_hit;
  logic [HIDX_W-1:0] bin_idx;
  logic             hash_hit;
  logic             bcast_c, mcast_c, accept_c;

  assign take = dst_valid & ~s1_vld;
  assign busy = s1_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      addr_q <= '0;
    end else begin
      s1_vld <= take;
      if (take) addr_q <= dst_addr;
    end
  end

  rx_addr_station_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
    .addr(addr_q), .slot_hi(sta_hi), .slot_lo(sta_lo),
    .slot_hit(slot_hit), .any_hit(station_hit)
  );

  rx_addr_hash_lookup u_hash (
    .addr(addr_q), .table_bits({hash_hi, hash_lo}),
    .bin_idx(bin_idx), .bin_hit(hash_hit)
  );

  rx_addr_decide u_decide (
    .addr(addr_q), .ctl(rcv_ctl), .station_hit(station_hit), .hash_hit(hash_hit),
    .is_bcast(bcast_c), .is_mcast(mcast_c), .accept(accept_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_mcast  <= 1'b0;
    end else begin
      res_valid  <= s1_vld;
      res_accept <= s1_vld & accept_c;
      res_mcast  <= s1_vld & mcast_c;
    end
  end

  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(take, 2));
  a_r10_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_accept && !res_mcast));
  a_r4_group_only: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && !addr_q[MAC_W-8]) |=> !res_mcast);
  a_r6_promisc: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && rcv_ctl[CTL_PROMISC]) |=> res_accept);
  a_r3_slot_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && $countones(slot_hit) > 0 && !addr_q[MAC_W-8]) |=> res_accept);
  a_r5_bcast_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && bcast_c && !rcv_ctl[CTL_BCAST] && !rcv_ctl[CTL_PROMISC]) |=> !res_accept);
  a_r8_bin_range: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && hash_hit && mcast_c && rcv_ctl[CTL_HASHMC]) |=> res_accept);
endmodule

// File: tb/rx_addr_filter_tb_top.sv
`timescale 1ns/100ps
module rx_addr_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dst_valid = 1'b0;
  logic [47:0] dst_addr = '0;
  logic [63:0] sta_hi;
  logic [127:0] sta_lo;
  logic [3:0] rcv_ctl = '0;
  logic [63:0] htab = '0;
  logic busy, res_valid, res_accept, res_mcast;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [47:0] S0 = 48'h021122334455;
  localparam logic [47:0] S1 = 48'h02AABBCCDDEE;
  localparam logic [47:0] S2 = 48'h00005E000102;
  localparam logic [47:0] S3 = 48'h060102030405;

  assign sta_hi = {S3[47:32], S2[47:32], S1[47:32], S0[47:32]};
  assign sta_lo = {S3[31:0], S2[31:0], S1[31:0], S0[31:0]};

  always #2.5 clk = ~clk;

  rx_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .dst_valid(dst_valid), .dst_addr(dst_addr),
    .sta_hi(sta_hi), .sta_lo(sta_lo), .rcv_ctl(rcv_ctl),
    .hash_lo(htab[31:0]), .hash_hi(htab[63:32]),
    .busy(busy), .res_valid(res_valid), .res_accept(res_accept), .res_mcast(res_mcast)
  );

  // Byte-at-a-time form of the reflected CRC.
  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++) begin
      c = c ^ {24'h0, a[47-8*b -: 8]};
      for (int k = 0; k < 8; k++)
        c = (c >> 1) ^ (c[0] ? 32'hEDB88320 : 32'h0);
    end
    return c;
  endfunction

  function automatic int ref_pos(input logic [47:0] a);
    logic [31:0] c = ref_crc(a);
    int idx = int'(c[31:26]);
    return 16 * (idx / 16) + 15 - (idx % 16);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [47:0] a, input string req, input bit ea, input bit em);
    @(negedge clk);
    dst_valid = 1'b1; dst_addr = a;
    @(negedge clk);
    dst_valid = 1'b0;
    @(negedge clk);
    check({req, " result"}, {5'b0, res_valid, res_accept, res_mcast}, {5'b0, 1'b1, ea, em});
    @(negedge clk);
    check({req, " pulse"}, {7'b0, res_valid}, 8'h0);
  endtask

  typedef struct packed {
    logic [47:0] addr;
    logic [3:0]  ctl;
    logic [1:0]  hsel;
    logic        acc;
    logic        mc;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{S0, 4'h0, 2'd0, 1'b1, 1'b0},                 // R3 R2 slot 0
    '{S3, 4'h0, 2'd0, 1'b1, 1'b0},                 // R3 slot 3
    '{S2, 4'h0, 2'd0, 1'b1, 1'b0},                 // R3 slot 2
    '{48'h021122334456, 4'h0, 2'd0, 1'b0, 1'b0},   // R3 miss
    '{48'h021122334456, 4'h2, 2'd0, 1'b1, 1'b0},   // R6
    '{48'hFFFFFFFFFFFF, 4'h0, 2'd0, 1'b0, 1'b0},   // R5
    '{48'hFFFFFFFFFFFF, 4'h1, 2'd0, 1'b1, 1'b0},   // R5
    '{48'hFFFFFFFFFFFF, 4'hC, 2'd3, 1'b0, 1'b0},   // R5 allmc/hash ignored
    '{48'hFFFFFFFFFFFF, 4'h2, 2'd0, 1'b1, 1'b0},   // R6
    '{48'h01005E000001, 4'h0, 2'd0, 1'b0, 1'b1},   // R4
    '{48'h01005E000001, 4'h4, 2'd0, 1'b1, 1'b1},   // R7
    '{48'h01005E000001, 4'h8, 2'd1, 1'b1, 1'b1},   // R8 own bin
    '{48'h01005E000001, 4'h8, 2'd2, 1'b0, 1'b1},   // R8 other bins
    '{48'h01005E000001, 4'h0, 2'd1, 1'b0, 1'b1},   // R8 disabled
    '{S1, 4'h8, 2'd0, 1'b1, 1'b0},                 // R3 slot 1
    '{48'h333300000001, 4'h1, 2'd0, 1'b0, 1'b1},   // R4 R5
    '{48'h0180C2000000, 4'h8, 2'd1, 1'b1, 1'b1},   // R8
    '{48'h0A0B0C0D0E0F, 4'hC, 2'd3, 1'b0, 1'b0}    // R3 unicast unaffected
  };

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {4'b0, busy, res_valid, res_accept, res_mcast}, 8'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {4'b0, busy, res_valid, res_accept, res_mcast}, 8'h0);

    for (int v = 0; v < NV; v++) begin
      rcv_ctl = VECS[v].ctl;
      case (VECS[v].hsel)
        2'd1: begin htab = '0; htab[ref_pos(VECS[v].addr)] = 1'b1; end
        2'd2: begin htab = '1; htab[ref_pos(VECS[v].addr)] = 1'b0; end
        2'd3: htab = '1;
        default: htab = '0;
      endcase
      lookup(VECS[v].addr, $sformatf("vector %0d R2-table", v), VECS[v].acc, VECS[v].mc);
    end

    // R8: single bin versus its non-reversed neighbour position
    rcv_ctl = 4'h8;
    for (int i = 0; i < 8; i++) begin
      logic [47:0] a = 48'h01005E000000 + 48'(i * 37);
      int p = ref_pos(a);
      int wrong = 16 * (p / 16) + (15 - (p % 16));
      htab = '0; htab[p] = 1'b1;
      lookup(a, "R8 bin set", 1'b1, 1'b1);
      htab = '0; htab[wrong] = 1'b1;
      lookup(a, "R8 reversed bin clear", 1'b0, 1'b1);
    end

    // R10: strobe in busy cycle ignored
    rcv_ctl = 4'h0; htab = '0;
    @(negedge clk);
    dst_valid = 1'b1; dst_addr = S0;
    @(negedge clk);
    check("R10 busy", {7'b0, busy}, 8'h1);
    dst_addr = 48'h0180C2000000; rcv_ctl = 4'h0;
    @(negedge clk);
    dst_valid = 1'b0;
    check("R10 first result", {6'b0, res_valid, res_accept}, 8'h3);
    check("R10 busy released", {7'b0, busy}, 8'h0);
    @(negedge clk);
    check("R10 ignored strobe", {6'b0, res_valid, res_mcast}, 8'h0);
    @(negedge clk);
    check("R10 no late result", {7'b0, res_valid}, 8'h0);

    // R1: reset during a lookup
    @(negedge clk);
    dst_valid = 1'b1; dst_addr = S1;
    @(negedge clk);
    dst_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 mid-flight reset", {4'b0, busy, res_valid, res_accept, res_mcast}, 8'h0);
    @(negedge clk);
    check("R1 no result after reset", {7'b0, res_valid}, 8'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule